// File: doc/BRIEF.md
# Receiver Gain Control Sequencer

This controller picks the front-end amplifier gain index for a packet receiver. It watches a stream of signal-strength (RSSI) samples that arrive with a valid strobe. While it waits for a packet, it requires two valid samples in a row that lie strictly above a programmable detection level. On the second such sample it declares a signal and chooses a gain. It then freezes that gain for the rest of the packet.

The choice depends on a 3-bit mode field. In automatic mode the block compares the sample with five ascending switch levels. Any other legal code forces a fixed gain.

A restart policy decides when the next gain search begins:
- With auto-restart enabled, the block waits for the end of the packet, then for the receive FIFO to drain, then for a programmable number of bit-period ticks before it searches again.
- With auto-restart disabled, the frozen gain is kept for the following packets.
- A restart command pulse starts a new search at any time.

Top module: `rx_gain_sequencer`

## Requirements
- R1: After a synchronous reset the block is waiting for a signal with `gain_idx` = 1, `cur_gain` = 1 and `sig_det` = 0. Gain indices are encoded 1 to 6 for G1 (maximum gain) to G6 (lowest gain); values 0 and 7 never appear.
- R2: While waiting, a detection occurs on the second of two consecutive valid samples with `rssi_smp` strictly greater than `det_thresh`. `sig_det` goes high on the clock edge that takes that second sample.
- R3: A valid sample at or below `det_thresh` clears the consecutive count. Cycles with `rssi_vld` low neither advance nor clear the count.
- R4: In automatic mode the chosen index is 1 plus the number of the five levels in `thr_bus` that the detecting sample strictly exceeds. Level k sits in bits [8k-1:8k-8], and the levels must be ascending.
- R5: For `gain_sel`, codes 1 to 6 force `gain_idx` to that same value one cycle later. Codes 0 and 7 select automatic mode.
- R6: While `sig_det` is high, `cur_gain` is frozen. In automatic mode `gain_idx` is frozen too, and further RSSI samples have no effect.
- R7: With `auto_rst_en` low, `pkt_done` and `fifo_empty` have no effect: `sig_det` stays high and the gain is kept.
- R8: With `auto_rst_en` high, `pkt_done` starts a drain wait. Once `fifo_empty` is seen, the block counts `ipd_cfg` pulses of `bit_tick`, and `sig_det` falls on the edge after the last pulse. Ticks seen before the FIFO is empty do not count. The gain is kept until the next detection.
- R9: A `restart_cmd` pulse drops `sig_det` on the next edge from any state and clears the consecutive count. It takes priority over a detection in the same cycle and keeps the held gain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rssi_smp | input | 8 | RSSI sample, larger means stronger |
| rssi_vld | input | 1 | Sample valid strobe |
| det_thresh | input | 8 | Detection level |
| thr_bus | input | 40 | Five ascending gain-switch levels, level 1 in the low byte |
| gain_sel | input | 3 | 0/7 automatic, 1..6 forced index |
| auto_rst_en | input | 1 | Enable automatic restart after a packet |
| restart_cmd | input | 1 | Restart pulse |
| fifo_empty | input | 1 | Receive FIFO empty |
| pkt_done | input | 1 | Packet finished pulse |
| ipd_cfg | input | 8 | Inter-packet delay in bit ticks |
| bit_tick | input | 1 | One pulse per bit period |
| gain_idx | output | 3 | Applied gain index |
| cur_gain | output | 3 | Gain index latched for the current packet |
| sig_det | output | 1 | Signal detected and gain frozen |

## Verification
A wrong internal state shows up at the ports within one clock:
- A miscounted run of samples makes `sig_det` rise one sample early or late.
- A bad comparator map shows as a wrong `gain_idx` on the very edge of detection.
- A stuck restart path leaves `sig_det` high after the configured number of ticks, or after a restart pulse.

The delay timer is checked at the tick before expiry and at expiry. Ticks during the drain phase are checked too, because a timer that counted them would release the block early.

// File: rtl/rgs_pkg.sv
package rgs_pkg;
  typedef enum logic [1:0] {
    ST_WAIT  = 2'd0,
    ST_HOLD  = 2'd1,
    ST_DRAIN = 2'd2,
    ST_DELAY = 2'd3
  } rgs_state_e;

  localparam int GW = 3;
  localparam logic [GW-1:0] G_TOP = 3'd1;

  function automatic logic sel_forced(input logic [GW-1:0] s);
    return (s != 3'd0) && (s != 3'd7);
  endfunction
endpackage

// File: rtl/rgs_gain_pick.sv
module rgs_gain_pick #(
  parameter int RSSI_W = 8,
  parameter int NTHR   = 5,
  parameter int GW     = 3
) (
  input  logic [RSSI_W-1:0]      rssi,
  input  logic [NTHR*RSSI_W-1:0] thr_bus,
  output logic [GW-1:0]          idx
);
  logic [NTHR-1:0] above;

  for (genvar k = 0; k < NTHR; k++) begin : g_cmp
    assign above[k] = rssi > thr_bus[k*RSSI_W +: RSSI_W];
  end

  always_comb begin
    idx = GW'(1);
    for (int k = 0; k < NTHR; k++) begin
      idx = idx + GW'(above[k]);
    end
  end
endmodule

// File: rtl/rgs_detect.sv
module rgs_detect #(
  parameter int RSSI_W = 8,
  parameter int RUN    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              arm,
  input  logic              vld,
  input  logic [RSSI_W-1:0] rssi,
  input  logic [RSSI_W-1:0] thresh,
  output logic              hit
);
  localparam int CW = $clog2(RUN + 1);
  logic [CW-1:0] cnt;
  logic          over;

  assign over = rssi > thresh;
  assign hit  = arm && vld && over && (cnt == CW'(RUN - 1));

  always_ff @(posedge clk) begin
    if (rst || clr || !arm) begin
      cnt <= '0;
    end else if (vld) begin
      if (!over || hit) cnt <= '0;
      else              cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/rgs_ipd_timer.sv
module rgs_ipd_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             run,
  input  logic             tick,
  input  logic [DLY_W-1:0] limit,
  output logic             done
);
  logic [DLY_W-1:0] cnt;

  assign done = run && (cnt >= limit);

  always_ff @(posedge clk) begin
    if (rst || clr)             cnt <= '0;
    else if (run && tick && !done) cnt <= cnt + DLY_W'(1);
  end
endmodule

// File: rtl/rx_gain_sequencer.sv
module rx_gain_sequencer
  import rgs_pkg::*;
#(
  parameter int RSSI_W = 8,
  parameter int NTHR   = 5,
  parameter int RUN    = 2,
  parameter int DLY_W  = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [RSSI_W-1:0]      rssi_smp,
  input  logic                   rssi_vld,
  input  logic [RSSI_W-1:0]      det_thresh,
  input  logic [NTHR*RSSI_W-1:0] thr_bus,
  input  logic [2:0]             gain_sel,
  input  logic                   auto_rst_en,
  input  logic                   restart_cmd,
  input  logic                   fifo_empty,
  input  logic                   pkt_done,
  input  logic [DLY_W-1:0]       ipd_cfg,
  input  logic                   bit_tick,
  output logic [2:0]             gain_idx,
  output logic [2:0]             cur_gain,
  output logic                   sig_det
);
  rgs_state_e st_q, st_d;
  logic          hit, take, tmr_done, forced;
  logic [GW-1:0] pick, auto_q, auto_d, gain_q, cur_q;
  logic          det_q;

  rgs_detect #(.RSSI_W(RSSI_W), .RUN(RUN)) u_det (
    .clk(clk), .rst(rst), .clr(restart_cmd), .arm(st_q == ST_WAIT),
    .vld(rssi_vld), .rssi(rssi_smp), .thresh(det_thresh), .hit(hit)
  );

  rgs_gain_pick #(.RSSI_W(RSSI_W), .NTHR(NTHR), .GW(GW)) u_pick (
    .rssi(rssi_smp), .thr_bus(thr_bus), .idx(pick)
  );

  rgs_ipd_timer #(.DLY_W(DLY_W)) u_tmr (
    .clk(clk), .rst(rst), .clr(restart_cmd || (st_q != ST_DELAY)),
    .run(st_q == ST_DELAY), .tick(bit_tick), .limit(ipd_cfg), .done(tmr_done)
  );

  assign forced = sel_forced(gain_sel);
  assign take   = hit && !restart_cmd;
  assign auto_d = take ? pick : auto_q;

  always_comb begin
    st_d = st_q;
    if (restart_cmd) begin
      st_d = ST_WAIT;
    end else begin
      unique case (st_q)
        ST_WAIT:  if (hit) st_d = ST_HOLD;
        ST_HOLD:  if (pkt_done && auto_rst_en) st_d = ST_DRAIN;
        ST_DRAIN: if (fifo_empty) st_d = ST_DELAY;
        ST_DELAY: if (tmr_done) st_d = ST_WAIT;
        default:  st_d = ST_WAIT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_WAIT;
      auto_q <= G_TOP;
      gain_q <= G_TOP;
      cur_q  <= G_TOP;
      det_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      auto_q <= auto_d;
      gain_q <= forced ? gain_sel : auto_d;
      if (take) cur_q <= forced ? gain_sel : pick;
      det_q  <= st_d != ST_WAIT;
    end
  end

  assign gain_idx = gain_q;
  assign cur_gain = cur_q;
  assign sig_det  = det_q;
endmodule

// File: rtl/rgs_chk.sv
module rgs_chk #(
  parameter int RSSI_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [RSSI_W-1:0] rssi_smp,
  input logic              rssi_vld,
  input logic [RSSI_W-1:0] det_thresh,
  input logic [2:0]        gain_sel,
  input logic              auto_rst_en,
  input logic              restart_cmd,
  input logic [2:0]        gain_idx,
  input logic [2:0]        cur_gain,
  input logic              sig_det
);
  // R1
  idx_range_chk: assert property (@(posedge clk) disable iff (rst)
    (gain_idx >= 3'd1) && (gain_idx <= 3'd6) && (cur_gain >= 3'd1) && (cur_gain <= 3'd6));

  // R2
  det_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sig_det) |-> ($past(rssi_vld) && ($past(rssi_smp) > $past(det_thresh))));

  // R5
  forced_gain_chk: assert property (@(posedge clk) disable iff (rst)
    ((gain_sel != 3'd0) && (gain_sel != 3'd7)) |=> (gain_idx == $past(gain_sel)));

  // R6
  held_gain_chk: assert property (@(posedge clk) disable iff (rst)
    (sig_det && $past(sig_det)) |-> $stable(cur_gain));

  // R7
  no_autorst_chk: assert property (@(posedge clk) disable iff (rst)
    (sig_det && !auto_rst_en && !restart_cmd) |=> sig_det);

  // R9
  restart_drop_chk: assert property (@(posedge clk) disable iff (rst)
    restart_cmd |=> !sig_det);
endmodule

bind rx_gain_sequencer rgs_chk #(.RSSI_W(RSSI_W)) u_chk (
  .clk(clk), .rst(rst), .rssi_smp(rssi_smp), .rssi_vld(rssi_vld),
  .det_thresh(det_thresh), .gain_sel(gain_sel), .auto_rst_en(auto_rst_en),
  .restart_cmd(restart_cmd), .gain_idx(gain_idx), .cur_gain(cur_gain),
  .sig_det(sig_det)
);

// File: tb/sim_rx_gain_sequencer.sv
`timescale 1ns/1ps
module sim_rx_gain_sequencer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [7:0]  rssi_smp = '0;
  logic        rssi_vld = 1'b0;
  logic [7:0]  det_thresh = 8'd20;
  logic [39:0] thr_bus = {8'd120, 8'd100, 8'd80, 8'd60, 8'd40};
  logic [2:0]  gain_sel = 3'd0;
  logic        auto_rst_en = 1'b0;
  logic        restart_cmd = 1'b0;
  logic        fifo_empty = 1'b0;
  logic        pkt_done = 1'b0;
  logic [7:0]  ipd_cfg = 8'd0;
  logic        bit_tick = 1'b0;
  logic [2:0]  gain_idx, cur_gain;
  logic        sig_det;
  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rx_gain_sequencer u0 (
    .clk(clk), .rst(rst), .rssi_smp(rssi_smp), .rssi_vld(rssi_vld),
    .det_thresh(det_thresh), .thr_bus(thr_bus), .gain_sel(gain_sel),
    .auto_rst_en(auto_rst_en), .restart_cmd(restart_cmd),
    .fifo_empty(fifo_empty), .pkt_done(pkt_done), .ipd_cfg(ipd_cfg),
    .bit_tick(bit_tick), .gain_idx(gain_idx), .cur_gain(cur_gain),
    .sig_det(sig_det)
  );

  // {gain_sel, rssi, expected gain_idx}
  localparam int NV = 11;
  localparam logic [13:0] VECS [NV] = '{
    {3'd0, 8'd30,  3'd1}, {3'd0, 8'd40,  3'd1}, {3'd0, 8'd41,  3'd2},
    {3'd0, 8'd70,  3'd3}, {3'd0, 8'd90,  3'd4}, {3'd0, 8'd110, 3'd5},
    {3'd0, 8'd121, 3'd6}, {3'd0, 8'd255, 3'd6}, {3'd7, 8'd90,  3'd4},
    {3'd3, 8'd200, 3'd3}, {3'd6, 8'd30,  3'd6}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic smp(input logic [7:0] v);
    @(negedge clk); rssi_smp = v; rssi_vld = 1'b1;
    @(negedge clk); rssi_vld = 1'b0; rssi_smp = '0;
  endtask

  task automatic restart();
    @(negedge clk); restart_cmd = 1'b1;
    @(negedge clk); restart_cmd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
    cyc(2);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(3); rst = 1'b0; cyc(1);
    // R1 reset state
    chk("R1 gain_idx", gain_idx, 1);
    chk("R1 cur_gain", cur_gain, 1);
    chk("R1 sig_det", sig_det, 0);

    // R2 / R4 / R5 vector walk
    for (int i = 0; i < NV; i++) begin
      restart();
      gain_sel = VECS[i][13:11];
      cyc(2);
      smp(VECS[i][10:3]);
      chk("R2 no detect after one sample", sig_det, 0);
      smp(VECS[i][10:3]);
      chk("R2 detect after two samples", sig_det, 1);
      chk("R4/R5 gain_idx", gain_idx, VECS[i][2:0]);
      chk("R4/R5 cur_gain", cur_gain, VECS[i][2:0]);
    end
    gain_sel = 3'd0;

    // R3 broken run, equal-to-threshold, invalid cycles
    restart();
    smp(8'd50); smp(8'd10); smp(8'd50);
    chk("R3 below clears count", sig_det, 0);
    smp(8'd20); smp(8'd50);
    chk("R3 equal clears count", sig_det, 0);
    @(negedge clk); rssi_smp = 8'd5; cyc(3); rssi_smp = '0;
    chk("R3 invalid sample ignored", sig_det, 0);
    smp(8'd70);
    chk("R3 invalid cycles kept count", sig_det, 1);
    chk("R3 gain", gain_idx, 3);

    // R6 frozen while detected
    restart(); smp(8'd45); smp(8'd45);
    smp(8'd255); smp(8'd255);
    chk("R6 gain_idx frozen", gain_idx, 2);
    chk("R6 cur_gain frozen", cur_gain, 2);

    // R7 no auto restart
    auto_rst_en = 1'b0; fifo_empty = 1'b1;
    @(negedge clk); pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
    tick(); tick();
    smp(8'd255); smp(8'd255);
    chk("R7 still detected", sig_det, 1);
    chk("R7 gain carried", gain_idx, 2);

    // R8 auto restart: drain, then delay
    restart(); smp(8'd70); smp(8'd70);
    auto_rst_en = 1'b1; ipd_cfg = 8'd3; fifo_empty = 1'b0;
    @(negedge clk); pkt_done = 1'b1; @(negedge clk); pkt_done = 1'b0;
    tick(); tick(); tick(); tick();
    chk("R8 held during drain", sig_det, 1);
    fifo_empty = 1'b1; cyc(2);
    tick(); tick();
    chk("R8 held before last tick", sig_det, 1);
    tick();
    chk("R8 released after delay", sig_det, 0);
    chk("R8 gain kept", gain_idx, 3);
    smp(8'd121); smp(8'd121);
    chk("R8 new search", gain_idx, 6);
    auto_rst_en = 1'b0;

    // R9 restart from hold, and against a same-cycle detection
    restart();
    chk("R9 restart drops detect", sig_det, 0);
    chk("R9 gain held", gain_idx, 6);
    smp(8'd50);
    @(negedge clk); rssi_smp = 8'd50; rssi_vld = 1'b1; restart_cmd = 1'b1;
    @(negedge clk); rssi_vld = 1'b0; restart_cmd = 1'b0;
    chk("R9 restart beats detect", sig_det, 0);
    smp(8'd50);
    chk("R9 count cleared", sig_det, 0);
    smp(8'd50);
    chk("R9 new detect", sig_det, 1);
    chk("R9 new gain", gain_idx, 2);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule